// File: doc/BRIEF.md
# External Interrupt Line Controller

This block turns level changes on general-purpose port pins into latched interrupt requests. It has a fixed number of interrupt lines. Line n always listens to pin n, and a 4-bit selector per line picks which port that pin comes from. Every pin passes through a two-flop synchroniser. The block then compares each synchronised pin with its value from the previous clock to find rising and falling transitions.

Each line has its own rising-edge enable, falling-edge enable and mask. When an enabled transition occurs on the selected pin, the line's pending flag is set, whether or not the line is masked. Software clears a pending flag by writing a 1 to it. The request output of a line is high while the line is both pending and unmasked. Software reaches the registers through a simple word-addressed write port and a combinational read port.

Register words, by word address, with the default of 16 lines:

| Address | Content |
|---|---|
| 0 to 3 | Selector words |
| 4 | Mask |
| 5 | Rising-edge enable |
| 6 | Falling-edge enable |
| 7 | Pending flags |

In general, with `W = ceil(LINES/4)` selector words, the mask is at word W, the rising-edge enable at W+1, the falling-edge enable at W+2 and the pending flags at W+3. In the mask, enable and pending words, bit n belongs to line n.

Top module: `extint_ctrl`

## Requirements
- R1: While `rst` is high on a clock edge, every selector, the mask, both edge enables and all pending flags return to 0. After reset, `irq` is 0 and every register word reads as 0.
- R2: The selector for line n is held in bits [4*(n%4)+3 : 4*(n%4)] of selector word n/4. For example, line 4 uses bits [3:0] of word 1. Line n takes its input from bit `p*LINES+n` of `port_in`, where p is the value in its selector. A selector value of `PORTS` or more connects the line to no pin, so the line never becomes pending.
- R3: Selector values are port indices. Value 0 selects the first port, 1 the second, and so on, so value 4 selects the fifth port.
- R4: When a line's rising-edge enable bit is 1, a 0-to-1 change on its selected pin sets its pending flag.
- R5: When a line's falling-edge enable bit is 1, a 1-to-0 change on its selected pin sets its pending flag.
- R6: When both enable bits of a line are 1, a change in either direction sets its pending flag.
- R7: When both enable bits of a line are 0, no pin activity sets its pending flag.
- R8: A pending flag is set even while its mask bit is 0. `irq[n]` is 1 exactly when line n is pending and its mask bit is 1.
- R9: Writing to the pending word clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value, and such a write never sets a flag.
- R10: If an enabled transition and a clearing write hit the same line on the same clock edge, the flag ends up set.
- R11: Suppose a pin change is first sampled on clock edge k. The flag it causes is set on edge k+2, and `irq` shows it after that edge.
- R12: Reading a selector, mask or enable word returns the value last written to it. Reading the pending word returns the current flags. Unused bits and unused addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_in | input | PORTS*LINES | Pin levels; bit p*LINES+n is pin n of port p |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Word address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | LINES | Per-line interrupt requests |

## Verification
Most wrong internal states become visible on the cycle after they arise. A pending flag that is set wrongly, missed, or cleared wrongly shows up on `irq` once the line is unmasked. While the line is masked, the same fault shows up when the pending word is read back. A wrong selector or synchroniser depth appears as a transition on the wrong pin or in the wrong cycle, measured against the two-edge latency. The bench keeps `irq` and `rdata` in lockstep with a behavioural model and compares them on every cycle, so any of these faults is reported within a cycle or two of its cause.

// File: rtl/extint_pkg.sv
package extint_pkg;

    localparam int SEL_W      = 4;
    localparam int DATA_W     = 32;
    localparam int FIELDS_PER = DATA_W / SEL_W / 2;   // four selectors per word

    typedef struct packed {
        logic             mask;
        logic             rise_en;
        logic             fall_en;
        logic [SEL_W-1:0] sel;
    } line_cfg_t;

    function automatic int map_words(input int lines);
        return (lines + FIELDS_PER - 1) / FIELDS_PER;
    endfunction

    function automatic int field_lo(input int line);
        return SEL_W * (line % FIELDS_PER);
    endfunction

endpackage

// File: rtl/extint_edge.sv
module extint_edge #(
    parameter int WIDTH = 80
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pins,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    logic [WIDTH-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pins;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise_o = sync_q & ~prev_q;
    assign fall_o = ~sync_q & prev_q;

    // A rising indication now must come from a low-to-high step two samples back.
    p_rise_origin_r11: assert property (@(posedge clk) disable iff (rst)
        (|rise_o) |-> ((rise_o & $past(meta_q)) == rise_o));

endmodule

// File: rtl/extint_line.sv
module extint_line #(
    parameter int PORTS = 5
) (
    input  logic                         clk,
    input  logic                         rst,
    input  extint_pkg::line_cfg_t        cfg,
    input  logic [PORTS-1:0]             rise_pins,
    input  logic [PORTS-1:0]             fall_pins,
    input  logic                         clr,
    output logic                         pend
);
    logic hit;
    logic rise_sel, fall_sel;

    always_comb begin
        rise_sel = 1'b0;
        fall_sel = 1'b0;
        for (int p = 0; p < PORTS; p++) begin
            if (int'(cfg.sel) == p) begin
                rise_sel = rise_pins[p];
                fall_sel = fall_pins[p];
            end
        end
    end

    assign hit = (cfg.rise_en & rise_sel) | (cfg.fall_en & fall_sel);

    always_ff @(posedge clk) begin
        if (rst) pend <= 1'b0;
        else     pend <= (pend & ~clr) | hit;
    end

    p_hit_wins_r10: assert property (@(posedge clk) disable iff (rst)
        hit |=> pend);

    p_drop_needs_w1c_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(pend) |-> $past(clr));

    p_set_needs_edge_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(hit));

endmodule

// File: rtl/extint_regfile.sv
module extint_regfile #(
    parameter int LINES  = 16,
    parameter int ADDR_W = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [extint_pkg::DATA_W-1:0] wdata,
    input  logic [LINES-1:0]              pend_i,
    output extint_pkg::line_cfg_t         cfg_o [LINES],
    output logic [LINES-1:0]              clr_o,
    output logic [extint_pkg::DATA_W-1:0] rdata
);
    import extint_pkg::*;

    localparam int MW     = map_words(LINES);
    localparam int A_MASK = MW;
    localparam int A_RISE = MW + 1;
    localparam int A_FALL = MW + 2;
    localparam int A_PEND = MW + 3;

    logic [SEL_W-1:0] sel_q [LINES];
    logic [LINES-1:0] mask_q, rise_q, fall_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < LINES; l++) sel_q[l] <= '0;
            mask_q <= '0;
            rise_q <= '0;
            fall_q <= '0;
        end else if (wr_en) begin
            for (int l = 0; l < LINES; l++) begin
                if (int'(addr) == l / FIELDS_PER)
                    sel_q[l] <= wdata[field_lo(l) +: SEL_W];
            end
            if (int'(addr) == A_MASK) mask_q <= wdata[LINES-1:0];
            if (int'(addr) == A_RISE) rise_q <= wdata[LINES-1:0];
            if (int'(addr) == A_FALL) fall_q <= wdata[LINES-1:0];
        end
    end

    assign clr_o = (wr_en && int'(addr) == A_PEND) ? wdata[LINES-1:0] : '0;

    generate
        for (genvar l = 0; l < LINES; l++) begin : g_cfg
            assign cfg_o[l] = '{mask: mask_q[l], rise_en: rise_q[l],
                                fall_en: fall_q[l], sel: sel_q[l]};
        end
    endgenerate

    always_comb begin
        rdata = '0;
        for (int l = 0; l < LINES; l++) begin
            if (int'(addr) == l / FIELDS_PER)
                rdata[field_lo(l) +: SEL_W] = sel_q[l];
        end
        if (int'(addr) == A_MASK) rdata[LINES-1:0] = mask_q;
        if (int'(addr) == A_RISE) rdata[LINES-1:0] = rise_q;
        if (int'(addr) == A_FALL) rdata[LINES-1:0] = fall_q;
        if (int'(addr) == A_PEND) rdata[LINES-1:0] = pend_i;
    end

    p_cfg_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(mask_q) && $stable(rise_q) && $stable(fall_q)));

endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl #(
    parameter int LINES  = 16,
    parameter int PORTS  = 5,
    parameter int ADDR_W = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [PORTS*LINES-1:0] port_in,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [31:0]            wdata,
    output logic [31:0]            rdata,
    output logic [LINES-1:0]       irq
);
    import extint_pkg::*;

    localparam int PINS   = PORTS * LINES;
    localparam int A_PEND = map_words(LINES) + 3;

    logic [PINS-1:0]  rise_all, fall_all;
    logic [LINES-1:0] pend, clr, mask;
    line_cfg_t        cfg [LINES];

    extint_edge #(.WIDTH(PINS)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .pins   (port_in),
        .rise_o (rise_all),
        .fall_o (fall_all)
    );

    extint_regfile #(.LINES(LINES), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .pend_i (pend),
        .cfg_o  (cfg),
        .clr_o  (clr),
        .rdata  (rdata)
    );

    generate
        for (genvar l = 0; l < LINES; l++) begin : g_line
            logic [PORTS-1:0] rp, fp;
            for (genvar p = 0; p < PORTS; p++) begin : g_pin
                assign rp[p] = rise_all[p*LINES + l];
                assign fp[p] = fall_all[p*LINES + l];
            end
            extint_line #(.PORTS(PORTS)) u_line (
                .clk       (clk),
                .rst       (rst),
                .cfg       (cfg[l]),
                .rise_pins (rp),
                .fall_pins (fp),
                .clr       (clr[l]),
                .pend      (pend[l])
            );
            assign mask[l] = cfg[l].mask;
        end
    endgenerate

    assign irq = pend & mask;

    initial begin
        p_line_fit_r2: assert (LINES <= 32 && PORTS <= 16);
    end

    p_pend_readback_r12: assert property (@(posedge clk) disable iff (rst)
        (int'(addr) == A_PEND) |-> (rdata[LINES-1:0] == pend));

endmodule

// File: tb/extint_ctrl_bench.sv
module extint_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 16;
    localparam int NP = 5;
    localparam int AW = 4;
    localparam int A_MASK = 4, A_RISE = 5, A_FALL = 6, A_PEND = 7;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NP*NL-1:0]  port_in = '0;
    logic              wr_en = 1'b0;
    logic [AW-1:0]     addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [NL-1:0]     irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string tag = "R1";

    // behavioural reference state
    int            msel [NL];
    logic [NL-1:0] mmask, mrise, mfall, mpend;
    logic [NP*NL-1:0] ms1, ms2, mpv;

    extint_ctrl #(.LINES(NL), .PORTS(NP), .ADDR_W(AW)) u_extint_ctrl (
        .clk(clk), .rst(rst), .port_in(port_in), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string t, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", t, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mread(input int a);
        logic [31:0] r = '0;
        for (int l = 0; l < NL; l++)
            if (a == l / 4) r[4*(l%4) +: 4] = msel[l][3:0];
        if (a == A_MASK) r[NL-1:0] = mmask;
        if (a == A_RISE) r[NL-1:0] = mrise;
        if (a == A_FALL) r[NL-1:0] = mfall;
        if (a == A_PEND) r[NL-1:0] = mpend;
        return r;
    endfunction

    task automatic model_edge();
        logic [NL-1:0] hit, clrm;
        if (rst) begin
            for (int l = 0; l < NL; l++) msel[l] = 0;
            mmask = '0; mrise = '0; mfall = '0; mpend = '0;
            ms1 = '0; ms2 = '0; mpv = '0;
            return;
        end
        hit = '0;
        for (int l = 0; l < NL; l++) begin
            if (msel[l] < NP) begin
                int b = msel[l] * NL + l;
                if (mrise[l] && ms2[b] && !mpv[b]) hit[l] = 1'b1;
                if (mfall[l] && !ms2[b] && mpv[b]) hit[l] = 1'b1;
            end
        end
        clrm = (wr_en && int'(addr) == A_PEND) ? wdata[NL-1:0] : '0;
        mpend = (mpend & ~clrm) | hit;
        if (wr_en) begin
            for (int l = 0; l < NL; l++)
                if (int'(addr) == l / 4) msel[l] = int'(wdata[4*(l%4) +: 4]);
            if (int'(addr) == A_MASK) mmask = wdata[NL-1:0];
            if (int'(addr) == A_RISE) mrise = wdata[NL-1:0];
            if (int'(addr) == A_FALL) mfall = wdata[NL-1:0];
        end
        mpv = ms2; ms2 = ms1; ms1 = port_in;
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check({tag, " irq"}, 64'(irq), 64'(mpend & mmask));
        check({tag, " rdata"}, 64'(rdata), 64'(mread(int'(addr))));
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        wr_en = 1'b1; addr = AW'(a); wdata = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic peek(input string t, input int a, input logic [31:0] exp);
        addr = AW'(a);
        #1;
        check(t, 64'(rdata), 64'(exp));
    endtask

    task automatic pin(input int p, input int l, input logic v);
        port_in[p*NL + l] = v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        steps(3);
        rst = 1'b0;
        // R1: everything cleared
        tag = "R1";
        step();
        check("R1 irq after reset", 64'(irq), 64'h0);
        for (int a = 0; a < 8; a++) peek("R1 R12 register zero", a, 32'h0);

        // R4 R11: rising edge on line 0, first port, exact latency
        tag = "R4";
        wr(A_RISE, 32'h0001);
        wr(A_MASK, 32'h0001);
        peek("R12 rise readback", A_RISE, 32'h0001);
        pin(0, 0, 1'b1);
        step(); check("R11 edge k", 64'(irq[0]), 64'h0);
        step(); check("R11 edge k+1", 64'(irq[0]), 64'h0);
        step(); check("R11 R4 edge k+2", 64'(irq[0]), 64'h1);

        // R9: writing 0 does nothing, writing 1 clears
        tag = "R9";
        wr(A_PEND, 32'h0000);
        peek("R9 zero write keeps", A_PEND, 32'h0001);
        wr(A_PEND, 32'h0001);
        peek("R9 one write clears", A_PEND, 32'h0000);

        // R10: clear coinciding with a fresh edge
        tag = "R10";
        wr(A_PEND, 32'h0);
        pin(0, 0, 1'b0); steps(4);
        peek("R10 falling ignored on rise-only line", A_PEND, 32'h0);
        pin(0, 0, 1'b1); steps(3);
        peek("R10 pending before race", A_PEND, 32'h1);
        pin(0, 0, 1'b0); steps(2);
        pin(0, 0, 1'b1); steps(2);
        wr(A_PEND, 32'h0001);
        peek("R10 edge beats clear", A_PEND, 32'h0001);
        wr(A_PEND, 32'h0001);
        peek("R10 later clear works", A_PEND, 32'h0000);

        // R5 R3: line 1 on second port, falling only
        tag = "R5";
        wr(0, 32'h0000_0010);
        wr(A_FALL, 32'h0002);
        wr(A_MASK, 32'h0003);
        pin(1, 1, 1'b1); steps(4);
        check("R5 rising ignored", 64'(irq[1]), 64'h0);
        pin(0, 1, 1'b0); pin(1, 1, 1'b0); steps(3);
        check("R5 R3 falling sets", 64'(irq[1]), 64'h1);
        wr(A_PEND, 32'h2);

        // R2 R3 R6: line 4 mapped to fifth port, both edges
        tag = "R6";
        wr(1, 32'h0000_0004);
        peek("R2 line 4 low nibble of word 1", 1, 32'h4);
        wr(A_RISE, 32'h0011);
        wr(A_FALL, 32'h0012);
        wr(A_MASK, 32'h0010);
        pin(0, 4, 1'b1); steps(4);
        check("R2 unselected port ignored", 64'(irq[4]), 64'h0);
        pin(4, 4, 1'b1); steps(3);
        check("R6 R3 rise on fifth port", 64'(irq[4]), 64'h1);
        wr(A_PEND, 32'h10);
        pin(4, 4, 1'b0); steps(3);
        check("R6 fall on fifth port", 64'(irq[4]), 64'h1);
        wr(A_PEND, 32'h10);

        // R8: masked line still becomes pending
        tag = "R8";
        wr(A_RISE, 32'h0004);
        wr(A_MASK, 32'h0000);
        pin(0, 2, 1'b1); steps(3);
        check("R8 masked irq low", 64'(irq[2]), 64'h0);
        peek("R8 masked pending set", A_PEND, 32'h0004);
        wr(A_MASK, 32'h0004);
        check("R8 unmask raises irq", 64'(irq[2]), 64'h1);
        wr(A_PEND, 32'h4);

        // R2: out-of-range selector on line 3
        tag = "R2";
        wr(0, 32'h0000_7000);
        wr(A_RISE, 32'h0008);
        wr(A_FALL, 32'h0008);
        wr(A_MASK, 32'h0008);
        for (int p = 0; p < NP; p++) pin(p, 3, 1'b1);
        steps(4);
        for (int p = 0; p < NP; p++) pin(p, 3, 1'b0);
        steps(4);
        peek("R2 no-pin selector never pends", A_PEND, 32'h0);

        // R7: no enables
        tag = "R7";
        wr(A_RISE, 32'h0); wr(A_FALL, 32'h0); wr(A_MASK, 32'hFFFF);
        port_in = '1; steps(4);
        port_in = '0; steps(4);
        peek("R7 no trigger no pending", A_PEND, 32'h0);

        // mixed traffic, model compare every cycle
        tag = "R12";
        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(3) == 0) port_in[$urandom_range(NP*NL-1)] ^= 1'b1;
            if ($urandom_range(7) == 0) begin
                wr_en = 1'b1;
                addr  = AW'($urandom_range(9));
                wdata = $urandom;
            end else begin
                wr_en = 1'b0;
                addr  = AW'($urandom_range(9));
            end
            step();
        end
        wr_en = 1'b0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule